// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external asynchronous static RAM of 131,072 bytes. The RAM has 17 address lines and eight data lines that carry data in both directions. Requests arrive on a valid/ready stream that carries a direction flag, an address and write data. Read results come back as a byte with a one-cycle valid pulse.

On the memory side the controller drives active-low chip select, write enable and output enable, along with the address. The shared data pins are split into three signals: a value to drive, a drive enable and the value sampled from the pins. Every timing interval of the memory is a parameter counted in whole clock cycles. Each count is the interval for the chosen speed grade divided by the clock period and rounded up. Grades 0, 1 and 2 select the 8 ns, 10 ns and 12 ns tables.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Between that edge and the completion of the access, `req_ready` stays low and a waiting requester must hold its fields. `rsp_valid` is not back-pressured: it is a single-cycle pulse.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and immediately after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only while no access is in progress. It is 0 from the edge after acceptance until the access completes.
- R3: For a write, `mem_we_n` is low for exactly WPC cycles, where WPC is the largest of three values: ceil(tWP/Tclk), ceil(tDW/Tclk) and ceil(tCYC/Tclk)-2 (at least 1). tWP is 6+g ns, tDW is 4+g ns and tCYC is 8+2g ns, for grade g. Throughout the write `mem_oe_n` stays 1 and `mem_cs_n` stays 0. `mem_dq_oe` rises together with the fall of `mem_we_n` and falls one edge after `mem_we_n` rises, on the same edge that `mem_cs_n` returns to 1. The byte driven is the request's write data.
- R4: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. `mem_we_n` and `mem_dq_oe` become active only on an edge before which `mem_oe_n` has been sampled high on at least HZC consecutive edges, where HZC = ceil((4+g) ns/Tclk). With no such wait, they become active on the edge after acceptance.
- R5: `mem_addr` takes the request address on the acceptance edge, together with the fall of `mem_cs_n`. The address and chip select then hold steady until the access ends. `mem_addr` never changes while `mem_we_n` is 0.
- R6: For a read, `mem_oe_n` stays low for exactly ACC = ceil((8+2g) ns/Tclk) cycles. The data pins are sampled on the edge that ends that window. `rsp_valid` is 1 for exactly one cycle after that edge, with `rsp_rdata` equal to the byte most recently written to that address.
- R7: A read that directly follows a write leaves one cycle with `mem_cs_n` low and `mem_oe_n` high after acceptance, so its result comes ACC+1 cycles after the acceptance edge. Any other read lowers `mem_oe_n` on the acceptance edge, and its result comes ACC cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Value to drive onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Value sampled from the data pins |

## Verification
Each result is checked against the clock edge on which it is due, all counted from the acceptance edge:
- the write strobe falls one edge after acceptance, or later when the output-disable wait of R4 applies; the bench computes that edge from the edge on which output enable last rose;
- the strobe stays low for WPC cycles, and the data drive and chip select release one edge after the strobe rises;
- read data arrives ACC or ACC+1 cycles after acceptance, depending on whether the previous access was a write.

Outputs are sampled one time unit after each rising edge for the bus monitor, and at falling edges for the per-access checks. Each comparison therefore sees the registered value of the edge in question. The sweeps alternate writes and reads so that every turnaround and drive-wait case occurs, across walking-one addresses and both address extremes.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPULSE,
    ST_WEND,
    ST_RTURN,
    ST_RACC
  } asram_state_e;

  // whole cycles covering an interval, never less than one
  function automatic int unsigned ceil_cycles(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  // interval for a speed grade: base plus step per grade, in ps
  function automatic int unsigned grade_ps(input int unsigned base_ns, input int unsigned step_ns,
                                           input int unsigned grade);
    return (base_ns + step_ns * grade) * 1000;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_bus_guard.sv
module asram_bus_guard #(
  parameter int unsigned HIZ_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  output logic hiz_ok
);
  localparam int unsigned HZ_W = $clog2(HIZ_CYC + 1);

  logic [HZ_W-1:0] high_cnt;

  // counts edges on which output enable was seen inactive, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_cnt <= HZ_W'(HIZ_CYC);
    end else if (!oe_n) begin
      high_cnt <= '0;
    end else if (high_cnt < HZ_W'(HIZ_CYC)) begin
      high_cnt <= high_cnt + 1'b1;
    end
  end

  assign hiz_ok = (high_cnt >= HZ_W'(HIZ_CYC));

  a_r4_guard_clears_on_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> !hiz_ok || (HIZ_CYC == 0));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ACC_CYC = 2,
  parameter int unsigned WP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              hiz_ok,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              cap_en
);
  localparam int unsigned CNT_MAX = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  asram_state_e     st;
  logic [CNT_W-1:0] cnt;
  logic             last_wr;

  assign req_ready = (st == ST_IDLE);
  assign cap_en    = (st == ST_RACC) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      last_wr <= 1'b0;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      addr    <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            cs_n    <= 1'b0;
            addr    <= req_addr;
            last_wr <= req_write;
            if (req_write) begin
              dq_out <= req_wdata;
              st     <= ST_WSET;
            end else if (last_wr) begin
              st <= ST_RTURN;
            end else begin
              oe_n <= 1'b0;
              cnt  <= CNT_W'(ACC_CYC - 1);
              st   <= ST_RACC;
            end
          end
        end
        ST_WSET: begin
          if (hiz_ok) begin
            we_n  <= 1'b0;
            dq_oe <= 1'b1;
            cnt   <= CNT_W'(WP_CYC - 1);
            st    <= ST_WPULSE;
          end
        end
        ST_WPULSE: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            st   <= ST_WEND;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WEND: begin
          dq_oe <= 1'b0;
          cs_n  <= 1'b1;
          st    <= ST_IDLE;
        end
        ST_RTURN: begin
          oe_n <= 1'b0;
          cnt  <= CNT_W'(ACC_CYC - 1);
          st   <= ST_RACC;
        end
        ST_RACC: begin
          if (cnt == '0) begin
            oe_n <= 1'b1;
            cs_n <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r3_oe_high_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !cs_n));

  a_r5_addr_held_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));

  a_r5_addr_moves_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> (we_n && $past(we_n)));

  a_r7_bus_free_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> (!dq_oe && $past(!dq_oe)));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> !req_ready);

endmodule

// File: rtl/asram_rd_path.sv
module asram_rd_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= dq_in;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned CLK_PS      = 5000,
  parameter int unsigned SPEED_GRADE = 0,
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned TCYC_CYC = ceil_cycles(grade_ps(8, 2, SPEED_GRADE), CLK_PS);
  localparam int unsigned ACC_CYC  = TCYC_CYC;
  localparam int unsigned WC_FILL  = (TCYC_CYC > 2) ? TCYC_CYC - 2 : 1;
  localparam int unsigned WP_CYC   = max3(ceil_cycles(grade_ps(6, 1, SPEED_GRADE), CLK_PS),
                                          ceil_cycles(grade_ps(4, 1, SPEED_GRADE), CLK_PS),
                                          WC_FILL);
  localparam int unsigned HIZ_CYC  = ceil_cycles(grade_ps(4, 1, SPEED_GRADE), CLK_PS);

  logic hiz_ok;
  logic cap_en;

  asram_bus_guard #(.HIZ_CYC(HIZ_CYC)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_n   (mem_oe_n),
    .hiz_ok (hiz_ok)
  );

  asram_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ACC_CYC (ACC_CYC),
    .WP_CYC  (WP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .hiz_ok    (hiz_ok),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .addr      (mem_addr),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe),
    .cap_en    (cap_en)
  );

  asram_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  a_r4_no_drive_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r4_drive_after_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(hiz_ok));

  a_r3_drive_spans_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;
  localparam int CLK_PERIOD = 4;
  localparam int GRADE      = 1;

  function automatic int cdiv(input int a, input int b);
    int n;
    n = (a + b - 1) / b;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_ACC = cdiv(8 + 2 * GRADE, CLK_PERIOD);
  localparam int E_WP  = imax(imax(cdiv(6 + GRADE, CLK_PERIOD), cdiv(4 + GRADE, CLK_PERIOD)),
                              (E_ACC > 2) ? E_ACC - 2 : 1);
  localparam int E_HIZ = cdiv(4 + GRADE, CLK_PERIOD);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  asram_ctrl #(.CLK_PS(CLK_PERIOD * 1000), .SPEED_GRADE(GRADE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and expected contents
  logic [7:0] sram [logic [16:0]];
  logic [7:0] expm [logic [16:0]];

  always @(posedge mem_we_n) begin
    if (mem_cs_n === 1'b0) sram[mem_addr] = mem_dq_out;
  end

  always @(mem_cs_n or mem_we_n or mem_oe_n or mem_addr) begin
    if (mem_cs_n === 1'b0 && mem_we_n === 1'b1 && mem_oe_n === 1'b0)
      mem_dq_in = sram[mem_addr];
    else
      mem_dq_in = 8'h00;
  end

  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor, sampled just after each edge
  int last_oe_rise = -100;
  int oe_fall = 0;
  int bus_hits = 0;
  int addr_hits = 0;
  int pulse_hits = 0;
  logic prev_oe = 1'b1, prev_cs = 1'b1, prev_rsp = 1'b0;
  logic [16:0] prev_addr = '0;

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) bus_hits++;
      if (!mem_cs_n && !prev_cs && mem_addr != prev_addr) addr_hits++;
      if (mem_addr != prev_addr && !mem_we_n) addr_hits++;
      if (rsp_valid && prev_rsp) pulse_hits++;
      if (!mem_oe_n && prev_oe) oe_fall = cyc;
      if (mem_oe_n && !prev_oe) begin
        last_oe_rise = cyc;
        chk(cyc - oe_fall == E_ACC, "R6 oe low width", cyc - oe_fall, E_ACC);
      end
    end
    prev_oe   = mem_oe_n;
    prev_cs   = mem_cs_n;
    prev_rsp  = rsp_valid;
    prev_addr = mem_addr;
  end

  bit prev_wr = 1'b0;

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int acc;
    int exp_fall;
    int n;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    exp_fall = imax(acc + 1, last_oe_rise + E_HIZ + 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    chk(!mem_cs_n && mem_addr == a, "R5 address on accept", mem_addr, a);
    while (mem_we_n) @(negedge clk);
    chk(cyc == exp_fall, "R4 strobe start edge", cyc, exp_fall);
    chk(mem_oe_n && mem_dq_oe && mem_dq_out == d, "R3 drive with oe high", mem_dq_out, d);
    n = 0;
    while (!mem_we_n) begin
      chk(mem_oe_n && !mem_cs_n, "R3 oe high cs low in pulse", mem_oe_n, 1);
      n++;
      @(negedge clk);
    end
    chk(n == E_WP, "R3 strobe width", n, E_WP);
    chk(mem_dq_oe && !mem_cs_n, "R3 data held past strobe", mem_dq_oe, 1);
    @(negedge clk);
    chk(!mem_dq_oe && mem_cs_n && req_ready, "R3 release with cs", mem_dq_oe, 0);
    expm[a] = d;
    prev_wr = 1'b1;
  endtask

  task automatic do_read(input logic [16:0] a);
    int acc;
    int lat;
    bit turn;
    turn = prev_wr;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    lat = E_ACC + (turn ? 1 : 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low during read", req_ready, 0);
    chk(mem_oe_n == turn, "R7 oe after accept", mem_oe_n, turn);
    chk(!mem_cs_n && mem_addr == a, "R5 read address", mem_addr, a);
    while (!rsp_valid) @(negedge clk);
    chk(cyc == acc + lat, "R7 read result edge", cyc - acc, lat);
    chk(rsp_rdata == expm[a], "R6 read data", rsp_rdata, expm[a]);
    prev_wr = 1'b0;
  endtask

  function automatic logic [7:0] pat(input logic [16:0] a, input int salt);
    return 8'((a * 29) + (a >> 9) + salt * 71 + 7);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && req_ready && !rsp_valid, "R1 bus released in reset", mem_dq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle after reset", mem_dq_oe, 0);

    // walking ones and extremes, writes back to back then reads back to back
    do_write(17'h00000, pat(17'h00000, 0));
    do_write(17'h1FFFF, pat(17'h1FFFF, 0));
    for (int i = 0; i < 17; i++) do_write(17'(1 << i), pat(17'(1 << i), 0));
    do_read(17'h00000);
    do_read(17'h1FFFF);
    for (int i = 0; i < 17; i++) do_read(17'(1 << i));

    // alternating write/read: turnaround and output-disable wait every time
    for (int i = 0; i < 64; i++) begin
      logic [16:0] a;
      a = 17'(i * 2053 + 11);
      do_write(a, pat(a, i + 1));
      do_read(a);
      do_write(a ^ 17'h1, pat(a, i + 2));
      do_read(a ^ 17'h1);
    end

    // overwrite then read the newest value
    do_write(17'h0ABCD, 8'h3C);
    do_write(17'h0ABCD, 8'hC3);
    do_read(17'h0ABCD);
    do_read(17'h0ABCD);

    repeat (2) @(negedge clk);
    chk(bus_hits == 0, "R4 no drive while oe low", bus_hits, 0);
    chk(addr_hits == 0, "R5 address held", addr_hits, 0);
    chk(pulse_hits == 0, "R6 single valid pulse", pulse_hits, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule